// File: doc/BRIEF.md
# Register-Driven SPI Command Sequencer

This block lets a host issue a single serial-flash command through four byte-wide registers on a plain register bus. The host first clears the buffer pointers. It then writes the opcode and any payload bytes to a write-data port and stores a packed length byte. Setting the start bit makes the block run the whole SPI transaction without further help. It lowers chip select, shifts out the opcode and payload, optionally clocks in a read phase, and releases chip select.

The start bit clears itself when the transaction ends, so the host polls it as a busy flag. The host then pulls the captured bytes from a read-data port one at a time. The serial side is SPI mode 0, MSB first. SCLK runs at the system clock divided by `2*HALF_DIV`.

Register map:

| Address | Register | Access |
|---|---|---|
| 0x10 | write data | write |
| 0x11 | read data | read |
| 0x12 | length | read and write |
| 0x13 | control and status | read and write |

A read request returns its value on `reg_rdata` in the cycle after `reg_rd`. In every other cycle `reg_rdata` is 0x00.

Top module: `spi_cmd_seq`

## Requirements
- R1: The first byte written to the write-data register is sent first as the opcode, and later writes to that register are sent after it in write order. Each byte goes out MSB first on `spi_mosi`, which is stable while `spi_sclk` is high.
- R2: Bits [3:0] of the length register give the number of payload bytes sent after the opcode, from 0 to 15.
- R3: Bits [7:4] of the length register give the number of bytes read minus one, so 0 reads one byte and 15 reads sixteen bytes. Read-phase bytes are sampled from `spi_miso` on rising SCLK edges, MSB first.
- R4: Writing 1 to control bit 0 starts a transaction. Reading the control register returns bit 0 = 1 until the transaction ends and 0 afterwards, and bit 2 = the no-read value latched at the start. Chip select is low only while bit 0 reads 1.
- R5: When control bit 2 is 1 in the starting write, no read phase occurs, whatever bits [7:4] of the length register hold.
- R6: Writing 1 to control bit 1 resets both buffer pointers. The next write-data write then becomes the opcode, and the next read-data read returns the first captured byte.
- R7: After completion, successive reads of the read-data register return the captured bytes in the order they arrived.
- R8: `spi_csn` falls 1.5 SCLK periods before the first rising SCLK edge and rises one SCLK period after the final falling SCLK edge. SCLK is low whenever `spi_csn` is high.
- R9: While a transaction runs, writes to the write-data, length and control registers have no effect.
- R10: A read of the read-data register beyond the captured count returns 0x00 and does not advance the pointer. Starting a transaction resets the read pointer to the first byte.
- R11: After reset, `spi_csn` is 1, `spi_sclk` and `spi_mosi` are 0, and the control and length registers read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, valid the cycle after reg_rd |
| spi_csn | output | 1 | SPI chip select, active low |
| spi_sclk | output | 1 | SPI clock, idle low |
| spi_mosi | output | 1 | SPI data to the device |
| spi_miso | input | 1 | SPI data from the device |

## Verification
The assertions assume that `spi_miso` changes only while SCLK is low. They also assume the host never issues a write and a read to the same register in one cycle. The bench responder therefore updates `spi_miso` only on falling SCLK edges and when chip select drops, and the host tasks drive one strobe at a time on the falling system clock edge. The over-read and frozen-length checks further assume that the read pointer and length only move through host accesses. The stimulus respects this by always waiting for the busy bit to clear before reloading registers, except in the one test that writes during a transaction on purpose.

// File: rtl/spi_seq_pkg.sv
`timescale 1ns/1ps
package spi_seq_pkg;
  localparam int BYTE_W = 8;
  localparam int NIB_W  = 4;
  localparam int DEPTH  = 1 << NIB_W;
  localparam int PTR_W  = NIB_W + 1;
  localparam int CNT_W  = NIB_W + 2;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [PTR_W-1:0]  ptr_t;
  typedef logic [CNT_W-1:0]  cnt_t;
  typedef logic [NIB_W-1:0]  idx_t;

  localparam ptr_t DEPTH_P = ptr_t'(DEPTH);

  localparam byte_t A_WDATA = 8'h10;
  localparam byte_t A_RDATA = 8'h11;
  localparam byte_t A_LEN   = 8'h12;
  localparam byte_t A_CTRL  = 8'h13;

  localparam int C_TRIG = 0;
  localparam int C_CLR  = 1;
  localparam int C_NORD = 2;

  typedef enum logic [1:0] {ST_IDLE, ST_LEAD, ST_SHIFT, ST_TRAIL} eng_state_t;
endpackage

// File: rtl/spi_seq_regs.sv
`timescale 1ns/1ps
module spi_seq_regs
  import spi_seq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  logic  rd_en,
  input  byte_t addr,
  input  byte_t wdata,
  output byte_t rdata,
  output logic  busy,
  output logic  start,
  output byte_t len_q,
  output logic  no_read,
  input  idx_t  tx_idx,
  output byte_t tx_byte,
  input  logic  rx_we,
  input  idx_t  rx_idx,
  input  byte_t rx_byte,
  input  logic  done,
  output ptr_t  rd_ptr,
  output ptr_t  rd_cnt
);
  byte_t wbuf [DEPTH];
  byte_t rbuf [DEPTH];

  ptr_t  wptr_q, wptr_d;
  ptr_t  rptr_q, rptr_d;
  ptr_t  rcnt_q, rcnt_d;
  byte_t len_d;
  logic  busy_q, busy_d;
  logic  start_q, start_d;
  logic  nord_q, nord_d;
  byte_t rdata_q, rdata_d;

  logic wr_wdata, wr_len, wr_ctrl, trig, clr, rd_rdata, wbuf_en;

  // host decode; busy blocks every write path
  assign wr_wdata = wr_en && (addr == A_WDATA) && !busy_q;
  assign wr_len   = wr_en && (addr == A_LEN)   && !busy_q;
  assign wr_ctrl  = wr_en && (addr == A_CTRL)  && !busy_q;
  assign trig     = wr_ctrl && wdata[C_TRIG];
  assign clr      = wr_ctrl && wdata[C_CLR];
  assign rd_rdata = rd_en && (addr == A_RDATA);
  assign wbuf_en  = wr_wdata && (wptr_q < DEPTH_P);

  always_comb begin
    wptr_d  = wptr_q;
    rptr_d  = rptr_q;
    rcnt_d  = rcnt_q;
    len_d   = len_q;
    busy_d  = busy_q;
    nord_d  = nord_q;
    start_d = trig;
    rdata_d = '0;

    if (clr)
      wptr_d = '0;
    else if (wbuf_en)
      wptr_d = wptr_q + ptr_t'(1);

    if (clr || trig)
      rptr_d = '0;
    else if (rd_rdata && (rptr_q < rcnt_q))
      rptr_d = rptr_q + ptr_t'(1);

    if (trig)
      rcnt_d = '0;
    else if (rx_we)
      rcnt_d = ptr_t'(rx_idx) + ptr_t'(1);

    if (wr_len)
      len_d = wdata;

    if (trig) begin
      busy_d = 1'b1;
      nord_d = wdata[C_NORD];
    end else if (done) begin
      busy_d = 1'b0;
    end

    if (rd_en) begin
      case (addr)
        A_RDATA: rdata_d = (rptr_q < rcnt_q) ? rbuf[rptr_q[NIB_W-1:0]] : '0;
        A_LEN:   rdata_d = len_q;
        A_CTRL:  rdata_d = {5'b0, nord_q, 1'b0, busy_q};
        default: rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      rcnt_q  <= '0;
      len_q   <= '0;
      busy_q  <= 1'b0;
      start_q <= 1'b0;
      nord_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      wptr_q  <= wptr_d;
      rptr_q  <= rptr_d;
      rcnt_q  <= rcnt_d;
      len_q   <= len_d;
      busy_q  <= busy_d;
      start_q <= start_d;
      nord_q  <= nord_d;
      rdata_q <= rdata_d;
    end
  end

  // byte buffers: no reset, written only under their enables
  always_ff @(posedge clk) begin
    if (wbuf_en)
      wbuf[wptr_q[NIB_W-1:0]] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rx_we)
      rbuf[rx_idx] <= rx_byte;
  end

  assign tx_byte = wbuf[tx_idx];
  assign rdata   = rdata_q;
  assign busy    = busy_q;
  assign start   = start_q;
  assign no_read = nord_q;
  assign rd_ptr  = rptr_q;
  assign rd_cnt  = rcnt_q;
endmodule

// File: rtl/spi_seq_tick.sv
`timescale 1ns/1ps
module spi_seq_tick #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == LAST);

  always_comb begin
    if (!run || tick)
      cnt_d = '0;
    else
      cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else
      cnt_q <= cnt_d;
  end
endmodule

// File: rtl/spi_seq_engine.sv
`timescale 1ns/1ps
module spi_seq_engine
  import spi_seq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start,
  input  byte_t len,
  input  logic  no_read,
  input  logic  tick,
  output logic  run,
  output logic  sclk,
  output logic  mosi,
  output logic  csn,
  input  logic  miso,
  output idx_t  tx_idx,
  input  byte_t tx_byte,
  output logic  rx_we,
  output idx_t  rx_idx,
  output byte_t rx_byte,
  output logic  done
);
  eng_state_t state_q, state_d;
  logic       half_q, half_d;
  logic       phase_q, phase_d;
  logic [2:0] bit_q, bit_d;
  cnt_t       byte_q, byte_d;
  cnt_t       txn_q, txn_d;
  cnt_t       rxn_q, rxn_d;
  byte_t      sreg_q, sreg_d;
  logic       csn_q, csn_d;
  logic       done_q, done_d;
  logic       rxwe_q, rxwe_d;
  idx_t       rxidx_q, rxidx_d;
  byte_t      rxbyte_q, rxbyte_d;

  cnt_t total;
  logic in_tx;

  assign total  = txn_q + rxn_q;
  assign in_tx  = byte_q < txn_q;
  assign tx_idx = byte_q[NIB_W-1:0];

  always_comb begin
    state_d  = state_q;
    half_d   = half_q;
    phase_d  = phase_q;
    bit_d    = bit_q;
    byte_d   = byte_q;
    txn_d    = txn_q;
    rxn_d    = rxn_q;
    sreg_d   = sreg_q;
    csn_d    = csn_q;
    done_d   = 1'b0;
    rxwe_d   = 1'b0;
    rxidx_d  = rxidx_q;
    rxbyte_d = rxbyte_q;

    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_LEAD;
          csn_d   = 1'b0;
          half_d  = 1'b0;
          phase_d = 1'b0;
          bit_d   = '0;
          byte_d  = '0;
          txn_d   = cnt_t'(len[NIB_W-1:0]) + cnt_t'(1);
          rxn_d   = no_read ? '0 : cnt_t'(len[BYTE_W-1:NIB_W]) + cnt_t'(1);
        end
      end
      ST_LEAD: begin
        if (tick) begin
          half_d = ~half_q;
          if (half_q)
            state_d = ST_SHIFT;
        end
      end
      ST_SHIFT: begin
        if (tick && !phase_q) begin
          phase_d = 1'b1;
          if (!in_tx) begin
            sreg_d = {sreg_q[BYTE_W-2:0], miso};
            if (bit_q == 3'd7) begin
              rxwe_d   = 1'b1;
              rxbyte_d = {sreg_q[BYTE_W-2:0], miso};
              rxidx_d  = byte_q[NIB_W-1:0] - txn_q[NIB_W-1:0];
            end
          end
        end else if (tick) begin
          phase_d = 1'b0;
          if (bit_q == 3'd7) begin
            bit_d = '0;
            if (byte_q == total - cnt_t'(1)) begin
              state_d = ST_TRAIL;
              half_d  = 1'b0;
            end else begin
              byte_d = byte_q + cnt_t'(1);
            end
          end else begin
            bit_d = bit_q + 3'd1;
          end
        end
      end
      ST_TRAIL: begin
        if (tick) begin
          half_d = ~half_q;
          if (half_q) begin
            state_d = ST_IDLE;
            csn_d   = 1'b1;
            done_d  = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      half_q   <= 1'b0;
      phase_q  <= 1'b0;
      bit_q    <= '0;
      byte_q   <= '0;
      txn_q    <= '0;
      rxn_q    <= '0;
      sreg_q   <= '0;
      csn_q    <= 1'b1;
      done_q   <= 1'b0;
      rxwe_q   <= 1'b0;
      rxidx_q  <= '0;
      rxbyte_q <= '0;
    end else begin
      state_q  <= state_d;
      half_q   <= half_d;
      phase_q  <= phase_d;
      bit_q    <= bit_d;
      byte_q   <= byte_d;
      txn_q    <= txn_d;
      rxn_q    <= rxn_d;
      sreg_q   <= sreg_d;
      csn_q    <= csn_d;
      done_q   <= done_d;
      rxwe_q   <= rxwe_d;
      rxidx_q  <= rxidx_d;
      rxbyte_q <= rxbyte_d;
    end
  end

  assign run     = (state_q != ST_IDLE);
  assign sclk    = phase_q;
  assign mosi    = (state_q == ST_SHIFT) && in_tx && tx_byte[3'd7 - bit_q];
  assign csn     = csn_q;
  assign done    = done_q;
  assign rx_we   = rxwe_q;
  assign rx_idx  = rxidx_q;
  assign rx_byte = rxbyte_q;
endmodule

// File: rtl/spi_cmd_seq.sv
`timescale 1ns/1ps
module spi_cmd_seq
  import spi_seq_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       spi_csn,
  output logic       spi_sclk,
  output logic       spi_mosi,
  input  logic       spi_miso
);
  logic  rst_meta, rst_sync_n;
  logic  busy, start, no_read, rx_we, done, tick, run;
  byte_t len_q, tx_byte, rx_byte;
  idx_t  tx_idx, rx_idx;
  ptr_t  rd_ptr, rd_cnt;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  spi_seq_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (reg_wr),
    .rd_en   (reg_rd),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .rdata   (reg_rdata),
    .busy    (busy),
    .start   (start),
    .len_q   (len_q),
    .no_read (no_read),
    .tx_idx  (tx_idx),
    .tx_byte (tx_byte),
    .rx_we   (rx_we),
    .rx_idx  (rx_idx),
    .rx_byte (rx_byte),
    .done    (done),
    .rd_ptr  (rd_ptr),
    .rd_cnt  (rd_cnt)
  );

  spi_seq_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .run   (run),
    .tick  (tick)
  );

  spi_seq_engine u_eng (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .start   (start),
    .len     (len_q),
    .no_read (no_read),
    .tick    (tick),
    .run     (run),
    .sclk    (spi_sclk),
    .mosi    (spi_mosi),
    .csn     (spi_csn),
    .miso    (spi_miso),
    .tx_idx  (tx_idx),
    .tx_byte (tx_byte),
    .rx_we   (rx_we),
    .rx_idx  (rx_idx),
    .rx_byte (rx_byte),
    .done    (done)
  );
endmodule

// File: rtl/spi_cmd_seq_chk.sv
`timescale 1ns/1ps
module spi_cmd_seq_chk
  import spi_seq_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       reg_rd,
  input logic [7:0] reg_addr,
  input logic [7:0] reg_rdata,
  input logic       spi_csn,
  input logic       spi_sclk,
  input logic       spi_mosi,
  input logic       busy,
  input byte_t      len_q,
  input ptr_t       rd_ptr,
  input ptr_t       rd_cnt
);
  AST_SCLK_LOW_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    spi_csn |-> !spi_sclk); // R8

  AST_CS_ONLY_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> spi_csn); // R4

  AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi)); // R1

  AST_BUSY_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == A_CTRL && busy) |=> reg_rdata[C_TRIG]); // R4

  AST_LEN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(len_q)); // R9

  AST_OVERREAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == A_RDATA && rd_ptr >= rd_cnt) |=> (reg_rdata == 8'h00)); // R10
endmodule

bind spi_cmd_seq spi_cmd_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .reg_rd    (reg_rd),
  .reg_addr  (reg_addr),
  .reg_rdata (reg_rdata),
  .spi_csn   (spi_csn),
  .spi_sclk  (spi_sclk),
  .spi_mosi  (spi_mosi),
  .busy      (busy),
  .len_q     (len_q),
  .rd_ptr    (rd_ptr),
  .rd_cnt    (rd_cnt)
);

// File: tb/test_spi_cmd_seq.sv
`timescale 1ns/1ps
module test_spi_cmd_seq;
  localparam int HALF = 2;
  localparam logic [7:0] AW = 8'h10, AR = 8'h11, AL = 8'h12, AC = 8'h13;
  // {opcode[24:17], payload count[16:13], read count-1[12:9], no-read[8], seed[7:0]}
  localparam int NV = 6;
  localparam logic [24:0] VECS [NV] = '{
    {8'h9F, 4'd0,  4'd2,  1'b0, 8'h11},
    {8'h02, 4'd3,  4'd0,  1'b1, 8'h22},
    {8'h0B, 4'd4,  4'd7,  1'b0, 8'h33},
    {8'h05, 4'd0,  4'd0,  1'b0, 8'h44},
    {8'hAB, 4'd15, 4'd15, 1'b0, 8'h55},
    {8'h06, 4'd0,  4'd9,  1'b1, 8'h66}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_addr = 8'h00, reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic spi_csn, spi_sclk, spi_mosi;
  logic spi_miso = 1'b0;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  spi_cmd_seq #(.HALF_DIV(HALF)) i_spi_cmd_seq (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .spi_csn(spi_csn), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  function automatic logic [7:0] pat(input logic [7:0] s, input int k);
    return 8'(s + 8'(k * 59));
  endfunction

  function automatic logic [7:0] pay(input logic [7:0] op, input int i);
    return 8'(op + 8'(i * 29 + 7));
  endfunction

  // SPI device model
  logic [7:0] rsp_seed = 8'h00;
  logic [7:0] mcap [32];
  logic [7:0] mshift = 8'h00;
  int mbits = 0, bcnt = 0;
  realtime t_cs_fall = 0, t_first_rise = 0, t_last_fall = 0, t_cs_rise = 0;

  always @(negedge spi_csn) begin
    logic [7:0] b;
    t_cs_fall = $realtime;
    mbits = 0;
    bcnt = 0;
    b = pat(rsp_seed, 0);
    spi_miso = b[7];
  end

  always @(posedge spi_sclk) if (!spi_csn) begin
    logic [7:0] nb;
    if (mbits == 0) t_first_rise = $realtime;
    nb = {mshift[6:0], spi_mosi};
    mshift = nb;
    if ((mbits % 8) == 7 && (mbits / 8) < 32) mcap[mbits / 8] = nb;
    mbits++;
  end

  always @(negedge spi_sclk) if (!spi_csn) begin
    logic [7:0] b;
    t_last_fall = $realtime;
    bcnt++;
    b = pat(rsp_seed, bcnt / 8);
    spi_miso = b[7 - (bcnt % 8)];
  end

  always @(posedge spi_csn) t_cs_rise = $realtime;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int t = 0; t < 5000; t++) begin
      rd(AC, s);
      if (!s[0]) return;
    end
    check("R4 busy never cleared", 1, 0);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11 reset state
    check("R11 csn", spi_csn, 1);
    check("R11 sclk", spi_sclk, 0);
    check("R11 mosi", spi_mosi, 0);
    rd(AC, d); check("R11 ctrl", d, 0);
    rd(AL, d); check("R11 len", d, 0);

    // vector table
    for (int k = 0; k < NV; k++) begin
      logic [7:0] op, sd;
      int nwr, nrd, nord, tx, rx;
      op = VECS[k][24:17];
      nwr = int'(VECS[k][16:13]);
      nrd = int'(VECS[k][12:9]);
      nord = int'(VECS[k][8]);
      sd = VECS[k][7:0];
      tx = nwr + 1;
      rx = nord ? 0 : nrd + 1;
      rsp_seed = sd;
      wr(AC, 8'h02);
      wr(AW, op);
      for (int i = 0; i < nwr; i++) wr(AW, pay(op, i));
      wr(AL, {4'(nrd), 4'(nwr)});
      wr(AC, {5'b0, 1'(nord), 2'b01});
      rd(AC, d); check("R4 busy after start", d[0], 1);
      wait_idle();
      rd(AC, d);
      check("R4 idle after end", d[0], 0);
      check("R4 no-read readback", d[2], nord);
      check(nord ? "R5 bit count" : "R3 bit count", mbits, 8 * (tx + rx));
      check("R1 opcode", mcap[0], op);
      for (int i = 0; i < nwr; i++) check("R2 payload", mcap[i + 1], pay(op, i));
      for (int j = 0; j < rx; j++) begin
        rd(AR, d); check("R7 read byte", d, pat(sd, tx + j));
      end
      rd(AR, d); check("R10 overread", d, 0);
      rd(AR, d); check("R10 overread again", d, 0);
      check("R8 lead time", int'(t_first_rise - t_cs_fall), 3 * HALF * 10);
      check("R8 trail time", int'(t_cs_rise - t_last_fall), 2 * HALF * 10);
    end

    // R9 writes during a transaction are ignored
    rsp_seed = 8'h70;
    wr(AC, 8'h02);
    wr(AW, 8'h3C);
    wr(AW, 8'h5A);
    wr(AL, 8'h01);
    wr(AC, 8'h01);
    wr(AW, 8'hEE);
    wr(AL, 8'hFF);
    wr(AC, 8'h02);
    wait_idle();
    rd(AL, d); check("R9 len kept", d, 8'h01);
    check("R9 opcode kept", mcap[0], 8'h3C);
    rd(AR, d); check("R7 single read", d, pat(8'h70, 2));
    wr(AW, 8'h99);
    wr(AL, 8'h02);
    wr(AC, 8'h01);
    wait_idle();
    check("R9 first txn opcode", mcap[0], 8'h3C);
    check("R9 payload 1", mcap[1], 8'h5A);
    check("R9 payload 2 not busy write", mcap[2], 8'h99);
    rd(AR, d); check("R10 new txn resets read pointer", d, pat(8'h70, 3));
    rd(AR, d); check("R10 overread", d, 0);
    wr(AC, 8'h02);
    rd(AR, d); check("R6 clear rewinds read pointer", d, pat(8'h70, 3));

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule